// File: doc/BRIEF.md
# Branch and Call Sequencer

This block decides which 64-bit instruction slot executes next. Each cycle it is offered one decoded instruction: its slot address, opcode byte, the 4-bit register-select field, the 16-bit offset, the 32-bit immediate and the two operand values read from the register file. From these it produces the next program counter along with flags. The flags report a taken transfer, the end of the program, an illegal or unserviceable control instruction, and a request to a platform helper routine together with that routine's number.

Conditional branches compare either full 64-bit operands or only their low 32 bits. The opcode's class field picks the width. Another opcode bit picks the second operand: the source register value, or the sign-extended immediate. Program-local calls push a return slot onto an internal stack, and the return instruction pops it. A return with nothing on the stack ends the program. Non-control instructions advance by one slot. The two-slot wide immediate load is the exception and advances by two. All outputs follow the current inputs and stack contents combinationally. Stack pushes and pops commit at the clock edge that ends a valid cycle.

Top module: `flow_sequencer`

## Requirements
- R1: With inst_valid high and an opcode whose low three bits are neither 5 nor 6, next_pc is pc_i+1 and taken, halt and err are low. The exception is opcode 0x18, the wide immediate load, for which next_pc is pc_i+2.
- R2: In class 5 (opcode bits [2:0]=5), opcode bits [7:4] select the condition. 1 is equal, 5 is not equal and 4 is "any common set bit". 2/3/0xa/0xb are unsigned greater, greater-or-equal, less and less-or-equal. 6/7/0xc/0xd are the signed versions of those four. All conditions compare the full 64 bits. A true condition gives taken=1 and next_pc=pc_i+1+sign-extended offset; a false one gives taken=0 and next_pc=pc_i+1.
- R3: In class 6 the same condition codes compare only bits [31:0] of both operands, with signedness judged at bit 31.
- R4: Opcode bit 3 set selects src_val as the second operand. Bit 3 clear selects imm sign-extended to 64 bits, and src_val is then ignored.
- R5: Code 0 is an unconditional jump. In class 5 (opcode 0x05) it goes to pc_i+1+sign-extended offset. In class 6 (opcode 0x06) it goes to pc_i+1+sign-extended imm, and the offset is ignored.
- R6: Opcode 0x85 with sreg_sel=1 is a local call. It pushes pc_i+1, sets taken and sets next_pc=pc_i+1+sign-extended imm.
- R7: Opcode 0x85 with sreg_sel 0 or 2 is a helper call. helper_req is high, helper_id equals imm, next_pc is pc_i+1, taken is low and the stack is untouched.
- R8: Opcode 0x95 with a non-empty stack pops the most recent return slot into next_pc and sets taken (last-in, first-out).
- R9: Opcode 0x95 with an empty stack raises halt and holds next_pc at pc_i.
- R10: A local call issued while the stack already holds RS_DEPTH entries raises err with taken low and next_pc=pc_i+1, and leaves the stack unchanged.
- R11: These cases raise err with next_pc=pc_i+1 and no stack change: codes 0xe and 0xf in class 5 or 6; opcodes 0x86 and 0x96; opcode 0x85 with sreg_sel above 2. Taken, halt, err and helper_req are never high together.
- R12: All slot arithmetic wraps modulo 2^PC_W.
- R13: While inst_valid is low, taken, halt, err and helper_req are low and the stack does not change. Reset empties the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inst_valid | input | 1 | Current instruction is real and may commit stack changes |
| pc_i | input | PC_W | Slot address of the current instruction |
| opcode | input | 8 | Opcode byte |
| sreg_sel | input | 4 | Source register field (call subtype for opcode 0x85) |
| offset | input | 16 | Signed slot offset |
| imm | input | 32 | Signed immediate |
| dst_val | input | 64 | Destination register value |
| src_val | input | 64 | Source register value |
| next_pc | output | PC_W | Slot address to execute next |
| taken | output | 1 | Control transferred away from sequential flow |
| halt | output | 1 | Outermost return: program finished |
| err | output | 1 | Illegal control instruction or return stack full |
| helper_req | output | 1 | Helper routine call strobe |
| helper_id | output | 32 | Helper routine number, zero when no request |

## Verification
The bench instantiates the block with PC_W=16 and RS_DEPTH=4. The narrow counter lets a jump near 0xFFFF demonstrate wrap-around, and it makes 32-bit call immediates truncate visibly. The four-entry stack lets a short run of nested calls reach the full condition and then unwind in last-in order down to the outermost return. Operand patterns are chosen to tell the widths and signedness apart: values that differ only above bit 31, and values that are negative when signed but large when unsigned.

// File: rtl/flow_pkg.sv
package flow_pkg;

   typedef enum logic [3:0] {
      JC_ALWAYS = 4'h0,
      JC_EQ     = 4'h1,
      JC_UGT    = 4'h2,
      JC_UGE    = 4'h3,
      JC_ANY    = 4'h4,
      JC_NE     = 4'h5,
      JC_SGT    = 4'h6,
      JC_SGE    = 4'h7,
      JC_CALL   = 4'h8,
      JC_RET    = 4'h9,
      JC_ULT    = 4'ha,
      JC_ULE    = 4'hb,
      JC_SLT    = 4'hc,
      JC_SLE    = 4'hd,
      JC_BADE   = 4'he,
      JC_BADF   = 4'hf
   } jcode_e;

   localparam logic [2:0] CLS_BR64 = 3'd5;
   localparam logic [2:0] CLS_BR32 = 3'd6;
   localparam logic [7:0] OP_WIDE_LOAD = 8'h18;

   localparam logic [3:0] CALL_HELPER_A = 4'd0;
   localparam logic [3:0] CALL_LOCAL    = 4'd1;
   localparam logic [3:0] CALL_HELPER_B = 4'd2;

   function automatic logic is_compare(input jcode_e c);
      case (c)
         JC_EQ, JC_UGT, JC_UGE, JC_ANY, JC_NE, JC_SGT, JC_SGE,
         JC_ULT, JC_ULE, JC_SLT, JC_SLE: is_compare = 1'b1;
         default: is_compare = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/cond_eval.sv
module cond_eval
   import flow_pkg::*;
#(
   parameter int W = 64
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  jcode_e       code,
   output logic         hit
);

   logic eq, ult, slt;

   assign eq  = (a == b);
   assign ult = (a < b);
   assign slt = ($signed(a) < $signed(b));

   always_comb begin
      case (code)
         JC_EQ:   hit = eq;
         JC_NE:   hit = !eq;
         JC_ANY:  hit = |(a & b);
         JC_UGT:  hit = !ult && !eq;
         JC_UGE:  hit = !ult;
         JC_ULT:  hit = ult;
         JC_ULE:  hit = ult || eq;
         JC_SGT:  hit = !slt && !eq;
         JC_SGE:  hit = !slt;
         JC_SLT:  hit = slt;
         JC_SLE:  hit = slt || eq;
         default: hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
   parameter int DW    = 32,
   parameter int DEPTH = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] top,
   output logic          empty,
   output logic          full
);

   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [DW-1:0]    slots [DEPTH];
   logic [CNT_W-1:0] cnt;
   logic [IDX_W-1:0] wr_idx, rd_idx;

   assign wr_idx = IDX_W'(cnt);
   assign rd_idx = IDX_W'(cnt - CNT_W'(1));
   assign empty  = (cnt == '0);
   assign full   = (cnt == CNT_W'(DEPTH));
   assign top    = slots[rd_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         for (int e = 0; e < DEPTH; e++) slots[e] <= '0;
      end else if (push && !full) begin
         slots[wr_idx] <= din;
         cnt           <= cnt + CNT_W'(1);
      end else if (pop && !empty) begin
         cnt <= cnt - CNT_W'(1);
      end
   end

endmodule

// File: rtl/flow_sequencer.sv
module flow_sequencer
   import flow_pkg::*;
#(
   parameter int PC_W     = 32,
   parameter int RS_DEPTH = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            inst_valid,
   input  logic [PC_W-1:0] pc_i,
   input  logic [7:0]      opcode,
   input  logic [3:0]      sreg_sel,
   input  logic [15:0]     offset,
   input  logic [31:0]     imm,
   input  logic [63:0]     dst_val,
   input  logic [63:0]     src_val,
   output logic [PC_W-1:0] next_pc,
   output logic            taken,
   output logic            halt,
   output logic            err,
   output logic            helper_req,
   output logic [31:0]     helper_id
);

   generate
      if (PC_W < 16 || PC_W > 32) begin : g_bad_pcw
         $error("flow_sequencer: PC_W must lie in 16..32");
      end
      if (RS_DEPTH < 1) begin : g_bad_depth
         $error("flow_sequencer: RS_DEPTH must be at least 1");
      end
   endgenerate

   localparam logic [PC_W-1:0] ONE = PC_W'(1);
   localparam logic [PC_W-1:0] TWO = PC_W'(2);

   logic [2:0]      cls;
   jcode_e          code;
   logic            use_reg, br64, br32;
   logic [63:0]     opnd_b;
   logic            hit64, hit32, cond;
   logic [PC_W-1:0] off_x, imm_x, pc_inc, seq_pc, rs_top;
   logic            rs_push, rs_pop, rs_empty, rs_full;

   assign cls     = opcode[2:0];
   assign code    = jcode_e'(opcode[7:4]);
   assign use_reg = opcode[3];
   assign br64    = (cls == CLS_BR64);
   assign br32    = (cls == CLS_BR32);
   assign opnd_b  = use_reg ? src_val : {{32{imm[31]}}, imm};
   assign off_x   = PC_W'($signed(offset));
   assign imm_x   = PC_W'($signed(imm));
   assign pc_inc  = pc_i + ONE;
   assign seq_pc  = (opcode == OP_WIDE_LOAD) ? pc_i + TWO : pc_inc;

   cond_eval #(.W(64)) u_cmp64 (
      .a(dst_val), .b(opnd_b), .code(code), .hit(hit64)
   );
   cond_eval #(.W(32)) u_cmp32 (
      .a(dst_val[31:0]), .b(opnd_b[31:0]), .code(code), .hit(hit32)
   );

   assign cond = br32 ? hit32 : hit64;

   ret_stack #(.DW(PC_W), .DEPTH(RS_DEPTH)) u_rs (
      .clk(clk), .rst_n(rst_n), .push(rs_push), .pop(rs_pop),
      .din(pc_inc), .top(rs_top), .empty(rs_empty), .full(rs_full)
   );

   always_comb begin
      next_pc    = seq_pc;
      taken      = 1'b0;
      halt       = 1'b0;
      err        = 1'b0;
      helper_req = 1'b0;
      rs_push    = 1'b0;
      rs_pop     = 1'b0;
      if (inst_valid && (br64 || br32)) begin
         case (code)
            JC_ALWAYS: begin
               taken   = 1'b1;
               next_pc = pc_inc + (br32 ? imm_x : off_x);
            end
            JC_CALL: begin
               if (br32) begin
                  err = 1'b1;
               end else if (sreg_sel == CALL_HELPER_A || sreg_sel == CALL_HELPER_B) begin
                  helper_req = 1'b1;
               end else if (sreg_sel == CALL_LOCAL) begin
                  if (rs_full) begin
                     err = 1'b1;
                  end else begin
                     rs_push = 1'b1;
                     taken   = 1'b1;
                     next_pc = pc_inc + imm_x;
                  end
               end else begin
                  err = 1'b1;
               end
            end
            JC_RET: begin
               if (br32) begin
                  err = 1'b1;
               end else if (rs_empty) begin
                  halt    = 1'b1;
                  next_pc = pc_i;
               end else begin
                  rs_pop  = 1'b1;
                  taken   = 1'b1;
                  next_pc = rs_top;
               end
            end
            default: begin
               if (!is_compare(code)) begin
                  err = 1'b1;
               end else if (cond) begin
                  taken   = 1'b1;
                  next_pc = pc_inc + off_x;
               end
            end
         endcase
      end
   end

   assign helper_id = helper_req ? imm : 32'd0;

endmodule

// File: rtl/flow_sequencer_chk.sv
module flow_sequencer_chk #(
   parameter int PC_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            inst_valid,
   input logic [PC_W-1:0] pc_i,
   input logic [7:0]      opcode,
   input logic [3:0]      sreg_sel,
   input logic [15:0]     offset,
   input logic [31:0]     imm,
   input logic [63:0]     dst_val,
   input logic [63:0]     src_val,
   input logic [PC_W-1:0] next_pc,
   input logic            taken,
   input logic            halt,
   input logic            err,
   input logic            helper_req,
   input logic [31:0]     helper_id
);

   logic [PC_W-1:0] off_x;
   logic            plain_cls;
   assign off_x     = PC_W'($signed(offset));
   assign plain_cls = (opcode[2:0] != 3'd5) && (opcode[2:0] != 3'd6);

   assert_seq_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      inst_valid && plain_cls && opcode != 8'h18 |-> next_pc == pc_i + PC_W'(1) && !taken);

   assert_wide_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      inst_valid && opcode == 8'h18 |-> next_pc == pc_i + PC_W'(2) && !taken);

   assert_ja_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
      inst_valid && opcode == 8'h05 |-> taken && next_pc == pc_i + PC_W'(1) + off_x);

   assert_helper_R7: assert property (@(posedge clk) disable iff (!rst_n)
      helper_req |-> helper_id == imm && next_pc == pc_i + PC_W'(1) && opcode == 8'h85);

   assert_halt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      halt |-> next_pc == pc_i && opcode == 8'h95);

   assert_err_seq_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !taken && next_pc == pc_i + PC_W'(1));

   assert_one_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({taken, halt, err, helper_req}));

   assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !inst_valid |-> !taken && !halt && !err && !helper_req);

endmodule

bind flow_sequencer flow_sequencer_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/tb_flow_sequencer.sv
module tb_flow_sequencer;

   localparam int PW = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          inst_valid;
   logic [PW-1:0] pc_i;
   logic [7:0]    opcode;
   logic [3:0]    sreg_sel;
   logic [15:0]   offset;
   logic [31:0]   imm;
   logic [63:0]   dst_val, src_val;
   logic [PW-1:0] next_pc;
   logic          taken, halt, err, helper_req;
   logic [31:0]   helper_id;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   flow_sequencer #(.PC_W(PW), .RS_DEPTH(4)) dut (
      .clk(clk), .rst_n(rst_n), .inst_valid(inst_valid), .pc_i(pc_i),
      .opcode(opcode), .sreg_sel(sreg_sel), .offset(offset), .imm(imm),
      .dst_val(dst_val), .src_val(src_val), .next_pc(next_pc),
      .taken(taken), .halt(halt), .err(err), .helper_req(helper_req),
      .helper_id(helper_id)
   );

   task automatic drive(input logic v, input logic [7:0] op, input logic [3:0] sr,
                        input logic [15:0] off, input logic [31:0] im,
                        input logic [63:0] dv, input logic [63:0] sv,
                        input logic [PW-1:0] pc);
      @(posedge clk);
      #1;
      inst_valid = v; opcode = op; sreg_sel = sr; offset = off;
      imm = im; dst_val = dv; src_val = sv; pc_i = pc;
   endtask

   task automatic chk(input string tag, input logic [PW-1:0] enp, input logic et,
                      input logic eh, input logic ee, input logic er);
      @(negedge clk);
      n_chk++;
      if (next_pc !== enp || taken !== et || halt !== eh || err !== ee || helper_req !== er) begin
         n_fail++;
         $display("FAIL %s: next_pc=%h taken=%b halt=%b err=%b req=%b expected %h %b %b %b %b",
                  tag, next_pc, taken, halt, err, helper_req, enp, et, eh, ee, er);
      end
   endtask

   task automatic chk_id(input string tag, input logic [31:0] eid);
      n_chk++;
      if (helper_id !== eid) begin
         n_fail++;
         $display("FAIL %s: helper_id=%h expected %h", tag, helper_id, eid);
      end
   endtask

   task automatic t_reset;
      drive(1'b0, 8'h85, 4'd1, 16'd0, 32'd5, 64'd0, 64'd0, 16'h0010);
      chk("R13 idle after reset", 16'h0011, 0, 0, 0, 0);
      drive(1'b1, 8'h95, 4'd0, 16'd0, 32'd0, 64'd0, 64'd0, 16'h0020);
      chk("R13 reset leaves stack empty", 16'h0020, 0, 1, 0, 0);
   endtask

   task automatic t_seq;
      drive(1'b1, 8'h07, 4'd0, 16'd9, 32'd3, 64'd1, 64'd1, 16'h0100);
      chk("R1 arithmetic op", 16'h0101, 0, 0, 0, 0);
      drive(1'b1, 8'h18, 4'd0, 16'd0, 32'h1234, 64'd0, 64'd0, 16'h0100);
      chk("R1 wide load", 16'h0102, 0, 0, 0, 0);
      drive(1'b1, 8'h61, 4'd2, 16'd4, 32'd0, 64'd0, 64'd0, 16'h0100);
      chk("R1 memory load", 16'h0101, 0, 0, 0, 0);
   endtask

   task automatic t_cond64;
      drive(1'b1, 8'h1d, 4'd0, 16'd5, 32'd0, 64'd7, 64'd7, 16'h0010);
      chk("R2 eq true", 16'h0016, 1, 0, 0, 0);
      drive(1'b1, 8'h1d, 4'd0, 16'd5, 32'd0, 64'h1_0000_0005, 64'd5, 16'h0010);
      chk("R2 eq upper bits differ", 16'h0011, 0, 0, 0, 0);
      drive(1'b1, 8'h2d, 4'd0, 16'd5, 32'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 16'h0010);
      chk("R2 unsigned gt", 16'h0016, 1, 0, 0, 0);
      drive(1'b1, 8'h6d, 4'd0, 16'd5, 32'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 16'h0010);
      chk("R2 signed gt false", 16'h0011, 0, 0, 0, 0);
      drive(1'b1, 8'hcd, 4'd0, 16'hFFFD, 32'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 16'h0010);
      chk("R2 signed lt back", 16'h000E, 1, 0, 0, 0);
      drive(1'b1, 8'h4d, 4'd0, 16'd2, 32'd0, 64'h8, 64'hC, 16'h0010);
      chk("R2 any set bit", 16'h0013, 1, 0, 0, 0);
      drive(1'b1, 8'hbd, 4'd0, 16'd2, 32'd0, 64'd9, 64'd9, 16'h0010);
      chk("R2 unsigned le equal", 16'h0013, 1, 0, 0, 0);
   endtask

   task automatic t_cond32;
      drive(1'b1, 8'h1e, 4'd0, 16'd5, 32'd0, 64'h1_0000_0005, 64'd5, 16'h0010);
      chk("R3 eq low half", 16'h0016, 1, 0, 0, 0);
      drive(1'b1, 8'h6e, 4'd0, 16'd5, 32'd0, 64'h0000_0000_8000_0000, 64'd1, 16'h0010);
      chk("R3 signed gt negative", 16'h0011, 0, 0, 0, 0);
      drive(1'b1, 8'h2e, 4'd0, 16'd5, 32'd0, 64'h0000_0000_8000_0000, 64'd1, 16'h0010);
      chk("R3 unsigned gt", 16'h0016, 1, 0, 0, 0);
   endtask

   task automatic t_src;
      drive(1'b1, 8'h15, 4'd0, 16'd4, 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 16'h0030);
      chk("R4 imm sign extended", 16'h0035, 1, 0, 0, 0);
      drive(1'b1, 8'h15, 4'd0, 16'd4, 32'hFFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF, 16'h0030);
      chk("R4 src ignored for imm form", 16'h0031, 0, 0, 0, 0);
   endtask

   task automatic t_ja;
      drive(1'b1, 8'h05, 4'd0, 16'd7, 32'd100, 64'd0, 64'd0, 16'h0020);
      chk("R5 jump by offset", 16'h0028, 1, 0, 0, 0);
      drive(1'b1, 8'h06, 4'd0, 16'd7, 32'd100, 64'd0, 64'd0, 16'h0020);
      chk("R5 jump by imm", 16'h0085, 1, 0, 0, 0);
      drive(1'b1, 8'h06, 4'd0, 16'd7, 32'hFFFF_FFDF, 64'd0, 64'd0, 16'h0020);
      chk("R5 jump by negative imm", 16'h0000, 1, 0, 0, 0);
   endtask

   task automatic t_wrap;
      drive(1'b1, 8'h07, 4'd0, 16'd0, 32'd0, 64'd0, 64'd0, 16'hFFFF);
      chk("R12 sequential wrap", 16'h0000, 0, 0, 0, 0);
      drive(1'b1, 8'h05, 4'd0, 16'h0020, 32'd0, 64'd0, 64'd0, 16'hFFF0);
      chk("R12 jump wrap", 16'h0011, 1, 0, 0, 0);
   endtask

   task automatic t_helper;
      drive(1'b1, 8'h85, 4'd0, 16'd0, 32'h0000_1234, 64'd0, 64'd0, 16'h0040);
      chk("R7 helper subtype 0", 16'h0041, 0, 0, 0, 1);
      chk_id("R7 helper id 0", 32'h0000_1234);
      drive(1'b1, 8'h85, 4'd2, 16'd0, 32'h0000_ABCD, 64'd0, 64'd0, 16'h0040);
      chk("R7 helper subtype 2", 16'h0041, 0, 0, 0, 1);
      chk_id("R7 helper id 2", 32'h0000_ABCD);
      drive(1'b1, 8'h95, 4'd0, 16'd0, 32'd0, 64'd0, 64'd0, 16'h0042);
      chk("R7 helper pushed nothing", 16'h0042, 0, 1, 0, 0);
   endtask

   task automatic t_call_ret;
      drive(1'b1, 8'h85, 4'd1, 16'd0, 32'h0000_0010, 64'd0, 64'd0, 16'h0050);
      chk("R6 local call", 16'h0061, 1, 0, 0, 0);
      drive(1'b1, 8'h85, 4'd1, 16'd0, 32'hFFFF_FFE0, 64'd0, 64'd0, 16'h0061);
      chk("R6 nested call back", 16'h0042, 1, 0, 0, 0);
      drive(1'b1, 8'h95, 4'd0, 16'd0, 32'd0, 64'd0, 64'd0, 16'h0045);
      chk("R8 inner return", 16'h0062, 1, 0, 0, 0);
      drive(1'b1, 8'h95, 4'd0, 16'd0, 32'd0, 64'd0, 64'd0, 16'h0070);
      chk("R8 outer return", 16'h0051, 1, 0, 0, 0);
      drive(1'b1, 8'h95, 4'd0, 16'd0, 32'd0, 64'd0, 64'd0, 16'h0055);
      chk("R9 outermost return halts", 16'h0055, 0, 1, 0, 0);
   endtask

   task automatic t_overflow;
      for (int k = 1; k <= 4; k++) begin
         drive(1'b1, 8'h85, 4'd1, 16'd0, 32'd0, 64'd0, 64'd0, PW'(k * 16'h0100));
         chk("R10 fill stack", PW'(k * 16'h0100 + 1), 1, 0, 0, 0);
      end
      drive(1'b1, 8'h85, 4'd1, 16'd0, 32'd0, 64'd0, 64'd0, 16'h0500);
      chk("R10 call when full", 16'h0501, 0, 0, 1, 0);
      for (int k = 4; k >= 1; k--) begin
         drive(1'b1, 8'h95, 4'd0, 16'd0, 32'd0, 64'd0, 64'd0, 16'h0900);
         chk("R10 unwind order", PW'(k * 16'h0100 + 1), 1, 0, 0, 0);
      end
      drive(1'b1, 8'h95, 4'd0, 16'd0, 32'd0, 64'd0, 64'd0, 16'h0900);
      chk("R10 stack unchanged by refused call", 16'h0900, 0, 1, 0, 0);
   endtask

   task automatic t_illegal;
      drive(1'b1, 8'he5, 4'd0, 16'd3, 32'd0, 64'd0, 64'd0, 16'h0010);
      chk("R11 code e wide class", 16'h0011, 0, 0, 1, 0);
      drive(1'b1, 8'hf6, 4'd0, 16'd3, 32'd0, 64'd0, 64'd0, 16'h0010);
      chk("R11 code f narrow class", 16'h0011, 0, 0, 1, 0);
      drive(1'b1, 8'h86, 4'd1, 16'd0, 32'd4, 64'd0, 64'd0, 16'h0010);
      chk("R11 call in narrow class", 16'h0011, 0, 0, 1, 0);
      drive(1'b1, 8'h96, 4'd0, 16'd0, 32'd0, 64'd0, 64'd0, 16'h0010);
      chk("R11 return in narrow class", 16'h0011, 0, 0, 1, 0);
      drive(1'b1, 8'h85, 4'd3, 16'd0, 32'd4, 64'd0, 64'd0, 16'h0010);
      chk("R11 call subtype 3", 16'h0011, 0, 0, 1, 0);
      drive(1'b1, 8'h95, 4'd0, 16'd0, 32'd0, 64'd0, 64'd0, 16'h0012);
      chk("R11 illegal ops pushed nothing", 16'h0012, 0, 1, 0, 0);
   endtask

   task automatic t_gate;
      drive(1'b0, 8'h85, 4'd1, 16'd0, 32'd8, 64'd0, 64'd0, 16'h0070);
      chk("R13 invalid call quiet", 16'h0071, 0, 0, 0, 0);
      drive(1'b0, 8'h05, 4'd0, 16'd8, 32'd0, 64'd0, 64'd0, 16'h0070);
      chk("R13 invalid jump quiet", 16'h0071, 0, 0, 0, 0);
      drive(1'b1, 8'h95, 4'd0, 16'd0, 32'd0, 64'd0, 64'd0, 16'h0074);
      chk("R13 invalid call pushed nothing", 16'h0074, 0, 1, 0, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; inst_valid = 1'b0; pc_i = '0; opcode = '0; sreg_sel = '0;
      offset = '0; imm = '0; dst_val = '0; src_val = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_seq();
      t_cond64();
      t_cond32();
      t_src();
      t_ja();
      t_wrap();
      t_helper();
      t_call_ret();
      t_overflow();
      t_illegal();
      t_gate();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule